// File: doc/BRIEF.md
# Mode-switchable receive FIFO

This block buffers received bytes for a 16550-style serial port model. It runs in one of two depths. In single mode it holds one byte, like a lone holding register. In queue mode it holds up to sixteen bytes in arrival order. The depth is chosen by a FIFO-enable input and can be changed at any time. Any change of depth discards whatever is stored. While queue mode stays on, a flush request also empties the buffer.

The byte source pushes with a strobe and a byte. It watches `space_o` and holds off while that output is low. If it pushes anyway, the byte is dropped and a one-cycle overflow pulse follows. The register-side consumer sees the oldest byte, the fill level and a non-empty flag. It pops one byte per strobe.

Top module: `rx_mode_fifo`

## Requirements
- R1: After reset `count_o` is 0, `not_empty_o` is 0, `space_o` is 1, `overflow_o` is 0 and the buffer is in single mode.
- R2: In single mode (`fifo_en_i` held at 0) the capacity is one byte: one accepted push drives `space_o` to 0.
- R3: In queue mode (`fifo_en_i` held at 1) the capacity is 16 bytes. `count_o` never exceeds the capacity of the current mode.
- R4: At a clock edge where `fifo_en_i` differs from the current mode, the buffer becomes empty and takes the capacity of the new mode. A push or pop in that cycle is ignored.
- R5: A flush (`flush_i`=1) while `fifo_en_i` is 1 and queue mode is already active empties the buffer at that edge. Capacity stays 16, and a push or pop in that cycle is ignored.
- R6: A flush while `fifo_en_i` is 0 and the buffer is in single mode has no effect on the stored byte or the count.
- R7: A push while the count equals the capacity is refused and the stored bytes are unchanged. `overflow_o` is 1 for exactly the following cycle. A pop in the same cycle still takes effect.
- R8: `space_o` is 1 exactly when the count is below the current capacity. It returns to 1 after the first pop from a full buffer.
- R9: Bytes leave in the order they were accepted, across any number of pointer wraps.
- R10: A pop while empty changes nothing. `pop_data_o` is 0xFF whenever the buffer is empty.
- R11: A push and a pop in the same cycle, with the buffer neither empty nor full, leave the count unchanged and advance the head by one byte.
- R12: `count_o` equals the number of stored bytes. `not_empty_o` is 1 exactly when that number is nonzero, and `pop_data_o` shows the oldest stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects 16-byte queue mode, 0 selects single-byte mode |
| flush_i | input | 1 | Empty the buffer (effective in queue mode only) |
| push_i | input | 1 | Push strobe from the byte source |
| push_data_i | input | 8 | Byte to push |
| space_o | output | 1 | Buffer can accept a byte |
| pop_i | input | 1 | Pop strobe from the consumer |
| pop_data_o | output | 8 | Oldest stored byte, 0xFF when empty |
| count_o | output | 5 | Number of stored bytes |
| not_empty_o | output | 1 | At least one byte stored |
| overflow_o | output | 1 | One-cycle pulse after a refused push |

## Verification
The bench fills both modes to the brim and pushes once more. A design that wrote into a full buffer would corrupt the head byte or wrap the count, and one that forgot the pulse would leave `overflow_o` low. It toggles the enable while bytes are stored and while strobes are active. Stale bytes surviving the switch, or a push leaking into the new mode, would show up as a wrong count or head. It also flushes while in single mode, where a block that honoured the request would lose the held byte, and it runs long mixed traffic across many wraps. A pointer that wrapped at 16 while the capacity was 1, or that did not wrap at all, would reorder or duplicate bytes.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_QUEUE  = 1'b1
  } rx_mode_e;

  typedef struct packed {
    logic clear;
    logic wr;
    logic rd;
    logic reject;
  } rx_op_t;
endpackage

// File: rtl/rx_fifo_mode_ctl.sv
module rx_fifo_mode_ctl
  import rx_fifo_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     fifo_en_i,
  input  logic     flush_i,
  output rx_mode_e mode_o,
  output logic     clear_o
);
  rx_mode_e mode_q;
  logic     switching;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_SINGLE;
    else         mode_q <= fifo_en_i ? MODE_QUEUE : MODE_SINGLE;
  end

  assign switching = fifo_en_i ^ (mode_q == MODE_QUEUE);
  // flush only honoured when queue mode is on and stays on
  assign clear_o   = switching | (flush_i & fifo_en_i & (mode_q == MODE_QUEUE));
  assign mode_o    = mode_q;
endmodule

// File: rtl/rx_fifo_ptrs.sv
module rx_fifo_ptrs
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] cap_i,
  output rx_op_t           op_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p,
                                           input logic [CNT_W-1:0] cap);
    if (CNT_W'(p) >= cap - CNT_W'(1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign full_o  = (cnt_q >= cap_i);
  assign empty_o = (cnt_q == '0);

  always_comb begin
    op_o.clear  = clear_i;
    op_o.wr     = push_i & ~full_o & ~clear_i;
    op_o.rd     = pop_i & ~empty_o & ~clear_i;
    op_o.reject = push_i & full_o & ~clear_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (op_o.clear) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (op_o.wr) wr_q <= adv(wr_q, cap_i);
      if (op_o.rd) rd_q <= adv(rd_q, cap_i);
      cnt_q <= cnt_q + CNT_W'(op_o.wr) - CNT_W'(op_o.rd);
    end
  end

  assign wr_idx_o = wr_q;
  assign rd_idx_o = rd_q;
  assign count_o  = cnt_q;
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DEPTH-1:0][DATA_W-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    cell_q <= '0;
      else if (wr_i && (wr_idx_i == PTR_W'(g)))        cell_q <= wr_data_i;
    end
    assign cells[g] = cell_q;
  end

  assign rd_data_o = cells[rd_idx_i];
endmodule

// File: rtl/rx_mode_fifo.sv
module rx_mode_fifo
  import rx_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter logic [DATA_W-1:0] EMPTY_FILL = '1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              space_o,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              not_empty_o,
  output logic              overflow_o
);
  rx_mode_e          mode;
  logic              clear;
  logic              queue_mode;
  logic [CNT_W-1:0]  cap;
  rx_op_t            op;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic              full, empty;
  logic [DATA_W-1:0] head;
  logic              ovf_q;

  rx_fifo_mode_ctl u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .flush_i   (flush_i),
    .mode_o    (mode),
    .clear_o   (clear)
  );

  assign queue_mode = (mode == MODE_QUEUE);
  assign cap        = queue_mode ? CNT_W'(DEPTH) : CNT_W'(1);

  rx_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .cap_i    (cap),
    .op_o     (op),
    .wr_idx_o (wr_idx),
    .rd_idx_o (rd_idx),
    .count_o  (count_o),
    .full_o   (full),
    .empty_o  (empty)
  );

  rx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (op.wr),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_data_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= op.reject;
  end

  assign space_o     = ~full;
  assign not_empty_o = ~empty;
  assign pop_data_o  = empty ? EMPTY_FILL : head;
  assign overflow_o  = ovf_q;
endmodule

// File: rtl/rx_mode_fifo_chk.sv
module rx_mode_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_en_i,
  input logic              flush_i,
  input logic              push_i,
  input logic              pop_i,
  input logic              space_o,
  input logic [DATA_W-1:0] pop_data_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              not_empty_o,
  input logic              overflow_o,
  input logic              mode_i
);
  logic steady;
  assign steady = (fifo_en_i == mode_i) && !(flush_i && fifo_en_i);

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= (mode_i ? DEPTH : 1));

  assert_mode_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i != mode_i) |=> (count_o == '0));

  assert_flush_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && fifo_en_i && mode_i) |=> (count_o == '0) && mode_i);

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && push_i && !space_o) |=> overflow_o);

  assert_reject_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && push_i && !space_o && !pop_i) |=> $stable(count_o));

  assert_ovf_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(push_i && !space_o));

  assert_space_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    space_o == (int'(count_o) < (mode_i ? DEPTH : 1)));

  assert_empty_fill_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !not_empty_o |-> (pop_data_o == '1));

  assert_pair_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && push_i && pop_i && not_empty_o && space_o) |=> $stable(count_o));

  assert_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_empty_o == (count_o != '0));
endmodule

bind rx_mode_fifo rx_mode_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_en_i   (fifo_en_i),
  .flush_i     (flush_i),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .space_o     (space_o),
  .pop_data_o  (pop_data_o),
  .count_o     (count_o),
  .not_empty_o (not_empty_o),
  .overflow_o  (overflow_o),
  .mode_i      (queue_mode)
);

// File: tb/rx_mode_fifo_tb.sv
module rx_mode_fifo_tb;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fifo_en_i = 1'b0, flush_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic          space_o, not_empty_o, overflow_o;
  logic [DW-1:0] pop_data_o;
  logic [CW-1:0] count_o;

  always #4 clk_i = ~clk_i;

  rx_mode_fifo u_dut (
    .clk_i, .rst_ni, .fifo_en_i, .flush_i, .push_i, .push_data_i,
    .space_o, .pop_i, .pop_data_o, .count_o, .not_empty_o, .overflow_o
  );

  logic [DW-1:0] mq[$];
  bit            m_queue = 1'b0;
  bit            m_ovf   = 1'b0;
  int            n_chk = 0, n_fail = 0;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    int cap = m_queue ? DEPTH : 1;
    check(tag, "count_o", int'(count_o), mq.size());
    check(tag, "not_empty_o", int'(not_empty_o), int'(mq.size() != 0));
    check(tag, "space_o", int'(space_o), int'(mq.size() < cap));
    check(tag, "pop_data_o", int'(pop_data_o), (mq.size() != 0) ? int'(mq[0]) : 'hFF);
    check(tag, "overflow_o", int'(overflow_o), int'(m_ovf));
  endtask

  task automatic step(string tag, bit psh, logic [DW-1:0] d, bit pp, bit en, bit fl);
    int  cap;
    bit  ok;
    @(negedge clk_i);
    push_i = psh; push_data_i = d; pop_i = pp; fifo_en_i = en; flush_i = fl;
    @(posedge clk_i);
    cap   = m_queue ? DEPTH : 1;
    m_ovf = 1'b0;
    if ((en != m_queue) || (fl && en && m_queue)) begin
      mq.delete();
      m_queue = en;
    end else begin
      ok = psh && (mq.size() < cap);
      if (psh && !ok) m_ovf = 1'b1;
      if (pp && mq.size() != 0) void'(mq.pop_front());
      if (ok) mq.push_back(d);
    end
    #2;
    compare(tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    #20;
    compare("R1");
    @(negedge clk_i) rst_ni = 1'b1;
    // R2 single mode, R7 overflow, R8 space return, R10 empty pop
    step("R2", 1, 8'h11, 0, 0, 0);
    step("R7", 1, 8'h22, 0, 0, 0);
    step("R7", 0, 8'h00, 0, 0, 0);
    step("R8", 0, 8'h00, 1, 0, 0);
    step("R10", 0, 8'h00, 1, 0, 0);
    step("R10", 0, 8'h00, 0, 0, 0);
    // R6 flush ignored while disabled
    step("R6", 1, 8'h33, 0, 0, 0);
    step("R6", 0, 8'h00, 0, 0, 1);
    // R4 enable with content and strobes active
    step("R4", 1, 8'h44, 1, 1, 0);
    // R3 fill to 16
    for (int i = 0; i < DEPTH; i++) step("R3", 1, 8'h50 + 8'(i), 0, 1, 0);
    step("R7", 1, 8'hEE, 0, 1, 0);
    step("R7", 1, 8'hEF, 1, 1, 0);
    step("R8", 0, 8'h00, 1, 1, 0);
    step("R8", 1, 8'h60, 0, 1, 0);
    step("R8", 0, 8'h00, 1, 1, 0);
    for (int i = 0; i < 4; i++) step("R11", 1, 8'h70 + 8'(i), 1, 1, 0);
    // R5 flush in queue mode, then refill shows capacity 16 kept
    step("R5", 1, 8'h99, 1, 1, 1);
    for (int i = 0; i < DEPTH + 1; i++) step("R5", 1, 8'hA0 + 8'(i), 0, 1, 0);
    // R4 back to single mode
    step("R4", 0, 8'h00, 0, 0, 0);
    step("R4", 1, 8'hB1, 0, 0, 0);
    step("R4", 1, 8'hB2, 0, 0, 0);
    step("R4", 0, 8'h00, 1, 1, 0);
    // R9 wrap traffic in queue mode
    for (int i = 0; i < 200; i++)
      step("R9", (i % 3) != 2, 8'(i * 7 + 3), (i % 4) == 1 || (i > 120), 1, 0);
    // R12 mixed random traffic including mode changes and flushes
    for (int i = 0; i < 3000; i++) begin
      bit en = fifo_en_i;
      if ($urandom_range(0, 199) == 0) en = ~en;
      step("R12", $urandom_range(0, 2) != 0, 8'($urandom), $urandom_range(0, 1) == 1,
           en, $urandom_range(0, 99) == 0);
    end
    finish_run();
  end
endmodule